// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the target of subroutine returns for an instruction fetch front end. Each time a call is fetched, the front end pulses the call strobe together with the address of the instruction that follows the call; the block stores that address as the newest entry. When a return is fetched, the front end pulses the return strobe and, in that same cycle, the block offers the newest stored address as the predicted return target together with a valid flag. The entry is then removed so that the next return sees the entry stored before it. Nested calls are therefore predicted in last-in, first-out order.

Storage is a ring of `DEPTH` address registers. When every slot is occupied, a further call overwrites the oldest address rather than stalling or raising an error. A call cycle by itself never produces a prediction; the call's own target comes from another predictor. A synchronous flush empties the stack, for example after a pipeline redirect. Only the count of occupied slots and one pointer are tracked, so entries beyond the occupied count are never reported.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: a return strobe yields `pred_valid_o` = 0 and `pred_target_o` = 0.
- R2: A cycle with `call_i` = 1 and `ret_i` = 0 stores `call_addr_i` as the newest entry and gives no prediction in that cycle (`pred_valid_o` = 0, `pred_target_o` = 0).
- R3: A cycle with `ret_i` = 1 on a non-empty stack drives `pred_valid_o` = 1 and `pred_target_o` = the newest entry in that same cycle (combinational), and removes that entry at the clock edge.
- R4: Entries are returned in last-in, first-out order across any mix of nested calls and returns.
- R5: With `DEPTH` entries held, a further call overwrites the oldest entry; the held count stays at `DEPTH`, and `DEPTH` returns then yield the newest `DEPTH` addresses newest first, after which a return is invalid. The ring pointer wraps modulo `DEPTH` on both push and pop.
- R6: A return on an empty stack yields `pred_valid_o` = 0 and `pred_target_o` = 0 and changes no state; a later call and return behave as on a fresh stack.
- R7: A cycle with both `call_i` = 1 and `ret_i` = 1 on a non-empty stack predicts the current newest entry and replaces it with `call_addr_i`, leaving the count unchanged; on an empty stack it gives no prediction and stores `call_addr_i` as the only entry.
- R8: `flush_i` = 1 empties the stack at the clock edge, overrides any call or return in the same cycle, and forces `pred_valid_o` = 0 and `pred_target_o` = 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Empty the stack at the next edge; masks prediction this cycle |
| call_i | input | 1 | A call is fetched this cycle |
| call_addr_i | input | ADDR_W | Sequential address following the call |
| ret_i | input | 1 | A return is fetched this cycle |
| pred_target_o | output | ADDR_W | Predicted return target, zero when not valid |
| pred_valid_o | output | 1 | The predicted target is usable |

## Verification
The embedded properties assume that `call_i`, `ret_i` and `flush_i` carry defined levels at every rising edge after reset is released, and that `call_addr_i` matters only in cycles where `call_i` is high. The stimulus honours this by changing every input only on the falling edge and always driving a defined value, including during reset. Overflow, empty returns, combined call-and-return cycles and flushes that coincide with strobes are reached both by directed sequences and by a long seeded stream compared against a queue-based model each cycle.

// File: rtl/ras_pkg.sv
// Package: shared types and ring-pointer helpers for the return address stack.
// Assumes depth arguments are at least 1.
package ras_pkg;

    // Operation chosen by the controller for one cycle.
    typedef enum logic [2:0] {
        RAS_IDLE  = 3'd0,
        RAS_PUSH  = 3'd1,
        RAS_POP   = 3'd2,
        RAS_SWAP  = 3'd3,
        RAS_CLEAR = 3'd4
    } ras_op_e;

    // Next index around a ring of d slots.
    function automatic int ring_next(input int p, input int d);
        return (p >= d - 1) ? 0 : p + 1;
    endfunction

    // Previous index around a ring of d slots.
    function automatic int ring_prev(input int p, input int d);
        return (p == 0) ? d - 1 : p - 1;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
// Module: ras_ctrl
// Tracks how many return addresses are held and where the next push lands.
// Decodes the call/return/flush strobes into one operation per cycle and
// tells the storage which slot to write and which slot is the newest.
// Assumes strobes are defined at every edge after reset.
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             call_i,
    input  logic             ret_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] top_idx_o,
    output logic             nonempty_o
);

    logic [PTR_W-1:0] nxt_ptr_q;   // slot the next push writes
    logic [CNT_W-1:0] count_q;     // occupied slots, saturates at DEPTH
    logic [PTR_W-1:0] nxt_ptr_inc;
    logic [PTR_W-1:0] nxt_ptr_dec;
    ras_op_e          op;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    assign nonempty_o  = (count_q != '0);
    assign nxt_ptr_inc = PTR_W'(ring_next(int'(nxt_ptr_q), DEPTH));
    assign nxt_ptr_dec = PTR_W'(ring_prev(int'(nxt_ptr_q), DEPTH));
    assign top_idx_o   = nxt_ptr_dec;

    // Purpose: pick this cycle's operation; flush wins, empty swap acts as push.
    always_comb begin
        if (flush_i)                      op = RAS_CLEAR;
        else if (call_i && ret_i)         op = nonempty_o ? RAS_SWAP : RAS_PUSH;
        else if (call_i)                  op = RAS_PUSH;
        else if (ret_i && nonempty_o)     op = RAS_POP;
        else                              op = RAS_IDLE;
    end

    // Purpose: steer the storage write to the free slot or to the newest slot.
    always_comb begin
        wr_en_o  = (op == RAS_PUSH) || (op == RAS_SWAP);
        wr_idx_o = (op == RAS_SWAP) ? nxt_ptr_dec : nxt_ptr_q;
    end

    // Purpose: advance pointer and occupancy for the chosen operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_ptr_q <= '0;
            count_q   <= '0;
        end else begin
            case (op)
                RAS_CLEAR: begin
                    nxt_ptr_q <= '0;
                    count_q   <= '0;
                end
                RAS_PUSH: begin
                    nxt_ptr_q <= nxt_ptr_inc;
                    if (count_q != FULL) count_q <= count_q + 1'b1;
                end
                RAS_POP: begin
                    nxt_ptr_q <= nxt_ptr_dec;
                    count_q   <= count_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5: occupancy never exceeds the ring size.
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);

    // R5: a push into a full ring keeps it full.
    a_r5_full_push_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !flush_i && count_q == FULL) |=> (count_q == FULL));

    // R6: a return on an empty ring leaves pointer and count alone.
    a_r6_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !flush_i && count_q == '0) |=> (count_q == '0) && $stable(nxt_ptr_q));

    // R7: call and return together on a non-empty ring keep depth and pointer.
    a_r7_swap_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i && !flush_i && count_q != '0) |=> $stable(count_q) && $stable(nxt_ptr_q));

    // R8: flush leaves the ring empty at the next cycle.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_q == '0) && (nxt_ptr_q == '0));

endmodule

// File: rtl/ras_store.sv
// Module: ras_store
// Ring of DEPTH address registers with one write port and one read port.
// Contents are not reset; the controller never reports unoccupied slots.
// Assumes wr_idx_i and rd_idx_i stay below DEPTH.
module ras_store #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: capture the write data when this slot is addressed.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PTR_W'(g))) slot_q[g] <= wr_data_i;
        end
    end

    // Purpose: select the slot named by the read index.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == PTR_W'(i)) rd_data_o = slot_q[i];
        end
    end

    // Write index must address an existing slot.
    a_r5_wr_idx_in_range: assert property (@(posedge clk)
        wr_en_i |-> (int'(wr_idx_i) < DEPTH));

endmodule

// File: rtl/ret_addr_stack.sv
// Module: ret_addr_stack (top)
// Circular return address stack: calls push the sequential return address,
// returns pop the newest address as a same-cycle prediction. Overflow
// overwrites the oldest entry. A synchronous flush empties the stack.
// Assumes at most one call and one return are reported per cycle.
module ret_addr_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_addr_i,
    input  logic              ret_i,
    output logic [ADDR_W-1:0] pred_target_o,
    output logic              pred_valid_o
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] top_idx;
    logic             nonempty;
    logic [ADDR_W-1:0] top_data;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .call_i     (call_i),
        .ret_i      (ret_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .top_idx_o  (top_idx),
        .nonempty_o (nonempty)
    );

    ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (call_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (top_data)
    );

    // Purpose: offer the newest entry on an unflushed return to a non-empty stack.
    always_comb begin
        pred_valid_o  = ret_i && !flush_i && nonempty;
        pred_target_o = pred_valid_o ? top_data : '0;
    end

    // R2: no prediction is ever offered without a return strobe.
    a_r2_no_pred_without_ret: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_i |-> !pred_valid_o);

    // R8: a flush cycle never reports a prediction.
    a_r8_flush_masks_pred: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !pred_valid_o && (pred_target_o == '0));

    // R6: an invalid prediction always carries a zero target.
    a_r6_invalid_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_o |-> (pred_target_o == '0));

endmodule

// File: tb/ret_addr_stack_tb_top.sv
// Bench: drives inputs on the falling edge, compares the outputs against a
// queue-based model just before each rising edge, then updates the model.
module ret_addr_stack_tb_top;

    localparam int AW = 32;
    localparam int D  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          call_i = 1'b0;
    logic [AW-1:0] call_addr_i = '0;
    logic          ret_i = 1'b0;
    logic [AW-1:0] pred_target_o;
    logic          pred_valid_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [AW-1:0] model_q [$];

    always #4 clk = ~clk;   // 125 MHz

    ret_addr_stack #(.ADDR_W(AW), .DEPTH(D)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .call_i        (call_i),
        .call_addr_i   (call_addr_i),
        .ret_i         (ret_i),
        .pred_target_o (pred_target_o),
        .pred_valid_o  (pred_valid_o)
    );

    // One cycle: drive, check against model, clock, update model.
    task automatic step(input logic c, input logic [AW-1:0] a, input logic r,
                        input logic f, input string tag);
        logic          exp_v;
        logic [AW-1:0] exp_t;
        @(negedge clk);
        call_i = c; call_addr_i = a; ret_i = r; flush_i = f;
        #2;
        if (!f && r && model_q.size() > 0) begin
            exp_v = 1'b1; exp_t = model_q[$];
        end else begin
            exp_v = 1'b0; exp_t = '0;
        end
        checks++;
        if (pred_valid_o !== exp_v || pred_target_o !== exp_t) begin
            failures++;
            $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
                     tag, pred_valid_o, pred_target_o, exp_v, exp_t);
        end
        @(posedge clk);
        if (f) model_q.delete();
        else if (c && r) begin
            if (model_q.size() > 0) model_q[$] = a;
            else model_q.push_back(a);
        end else if (c) begin
            if (model_q.size() == D) void'(model_q.pop_front());
            model_q.push_back(a);
        end else if (r && model_q.size() > 0) void'(model_q.pop_back());
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        step(0, '0, 1, 0, "R1");
        // R2: call alone gives no prediction
        step(1, 32'h0000_1004, 0, 0, "R2");
        step(0, '0, 0, 0, "R2");
        // R3: return predicts newest entry in the same cycle
        step(0, '0, 1, 0, "R3");
        step(0, '0, 1, 0, "R3");
        // R4: nested order
        step(1, 32'h0000_2000, 0, 0, "R4");
        step(1, 32'h0000_2100, 0, 0, "R4");
        step(0, '0, 1, 0, "R4");
        step(1, 32'h0000_2200, 0, 0, "R4");
        step(0, '0, 1, 0, "R4");
        step(0, '0, 1, 0, "R4");
        // R6: empty return is ignored, then fresh behaviour
        step(0, '0, 1, 0, "R6");
        step(0, '0, 1, 0, "R6");
        step(1, 32'h0000_3000, 0, 0, "R6");
        step(0, '0, 1, 0, "R6");
        step(0, '0, 1, 0, "R6");
        // R5: overflow overwrites oldest, pointer wraps both ways
        for (int i = 0; i < D + 2; i++) step(1, 32'h0000_4000 + AW'(i * 4), 0, 0, "R5");
        for (int i = 0; i < D + 1; i++) step(0, '0, 1, 0, "R5");
        for (int i = 0; i < 2 * D; i++) step(1, 32'h0000_4800 + AW'(i * 4), 0, 0, "R5");
        for (int i = 0; i < D; i++) step(0, '0, 1, 0, "R5");
        // R7: simultaneous call and return
        step(1, 32'h0000_5000, 0, 0, "R7");
        step(1, 32'h0000_5100, 1, 0, "R7");
        step(0, '0, 1, 0, "R7");
        step(0, '0, 1, 0, "R7");
        step(1, 32'h0000_5200, 1, 0, "R7");
        step(0, '0, 1, 0, "R7");
        step(0, '0, 1, 0, "R7");
        // R8: flush overrides strobes and empties
        step(1, 32'h0000_6000, 0, 0, "R8");
        step(1, 32'h0000_6100, 0, 0, "R8");
        step(1, 32'h0000_6200, 1, 1, "R8");
        step(0, '0, 1, 0, "R8");
        step(1, 32'h0000_6300, 0, 0, "R8");
        step(0, '0, 1, 1, "R8");
        step(0, '0, 1, 0, "R8");
        // R4: seeded mixed stream
        for (int i = 0; i < 3000; i++) begin
            int unsigned rv;
            rv = $urandom;
            step(rv[0] | rv[1], {rv[31:10], 10'h0} + AW'(i), rv[2] & (rv[3] | rv[4]),
                 (rv[9:5] == 5'd0), "R4");
        end
        finish_run();
    end

endmodule